// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a vector of already-synchronized GPIO inputs and raises one interrupt request toward a parent interrupt controller. Each pin is set up independently: it can fire on a level or on an edge. In edge mode it can watch one edge, rising or falling, or both edges. The polarity bit is read differently in the two modes. In single-edge mode a 1 picks the rising edge. In level mode a 1 picks active-low. An edge is held in a per-pin latch until software clears it. A level source has no latch and simply follows the pin.

Software reaches the block over a plain word-wide write/read port. Every register kind holds 32 pins per word. The enable register gates which pending sources reach the output. The status register shows every pending source, whether it is enabled or not. The output is the OR of all sources that are both pending and enabled, registered once.

Top module: `pin_event_irq`

## Requirements
- R1: Byte address = 8*kind + 4*bank. Kind 0 selects the edge-mode register, kind 1 both-edge, kind 2 polarity, kind 3 enable, kind 4 clear and kind 5 status (read-only). Pin n is bit n%32 of bank n/32. Writes to kinds 0 to 4 store the word, and a read returns it.
- R2: Reset clears every configuration register to 0, which means level mode, active-high, masked, with clear bits at 0. irq_out is low and status reads 0 while all pins are low.
- R3: With edge-mode bit 0, a pin is pending while it equals NOT its polarity bit (polarity 0 is active-high, 1 is active-low). Status follows the pin in the same cycle, and nothing is latched.
- R4: With edge-mode bit 1 and both-edge bit 0, polarity 1 latches a rising edge and polarity 0 latches a falling edge. An edge is a change of the pin from its value in the previous cycle. It shows in status one cycle after the pin changes, and it stays there until cleared, even while the pin holds steady.
- R5: With both-edge bit 1 in edge mode, both rising and falling edges latch, and polarity has no effect.
- R6: A write that turns a pin's clear bit from 0 to 1 clears that pin's latch. Writing 1 over a stored 1 clears nothing. The clear register keeps the value written.
- R7: An edge detected in the same cycle as its pin's clear wins, and the latch stays set.
- R8: Status shows pending sources before masking. irq_out goes high one cycle after any pending source is also enabled, and it is low when none is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | ADDR_W | Byte address: kind and bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | NPINS | Synchronized pin levels |
| irq_out | output | 1 | Combined interrupt request to the parent controller |

## Verification
If a pin's latch is wrong, it shows in the status word for its bank in the very next cycle. It also reaches irq_out one cycle after that, provided the pin is enabled. A wrong previous-cycle sample shows as an edge that is reported too early, too late, or twice, so the bench tracks every status read against its own cycle-by-cycle model. Errors in decoding a configuration register show as soon as that register is read back, or as soon as the pin it governs changes level.

// File: rtl/irq_pkg.sv
package irq_pkg;
    parameter int WORD_W = 32;

    typedef enum logic [2:0] {
        K_MODE = 3'd0,
        K_BOTH = 3'd1,
        K_POL  = 3'd2,
        K_EN   = 3'd3,
        K_CLR  = 3'd4,
        K_STAT = 3'd5
    } reg_kind_e;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pkg::*;
#(
    parameter int NPINS  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    input  logic [NPINS-1:0]  pending,
    output logic [NPINS-1:0]  mode,
    output logic [NPINS-1:0]  both,
    output logic [NPINS-1:0]  pol,
    output logic [NPINS-1:0]  en,
    output logic [NPINS-1:0]  clr_pulse
);
    localparam int NBANK = NPINS / WORD_W;
    localparam int BB    = (NBANK > 1) ? $clog2(NBANK) : 1;

    typedef struct packed {
        logic [NPINS-1:0] mode;
        logic [NPINS-1:0] both;
        logic [NPINS-1:0] pol;
        logic [NPINS-1:0] en;
        logic [NPINS-1:0] clr;
    } cfg_t;

    cfg_t            st_q, st_d;
    logic [2:0]      kind;
    logic [BB-1:0]   bank;
    logic [1:0]      unused_lsb;

    assign unused_lsb = addr[1:0];

    always_comb begin
        kind      = addr[BB+4:BB+2];
        bank      = addr[BB+1:2];
        st_d      = st_q;
        clr_pulse = '0;
        rdata     = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (int'(bank) == b) begin
                case (kind)
                    K_MODE: begin
                        rdata = st_q.mode[b*WORD_W +: WORD_W];
                        if (we) st_d.mode[b*WORD_W +: WORD_W] = wdata;
                    end
                    K_BOTH: begin
                        rdata = st_q.both[b*WORD_W +: WORD_W];
                        if (we) st_d.both[b*WORD_W +: WORD_W] = wdata;
                    end
                    K_POL: begin
                        rdata = st_q.pol[b*WORD_W +: WORD_W];
                        if (we) st_d.pol[b*WORD_W +: WORD_W] = wdata;
                    end
                    K_EN: begin
                        rdata = st_q.en[b*WORD_W +: WORD_W];
                        if (we) st_d.en[b*WORD_W +: WORD_W] = wdata;
                    end
                    K_CLR: begin
                        rdata = st_q.clr[b*WORD_W +: WORD_W];
                        if (we) begin
                            st_d.clr[b*WORD_W +: WORD_W]      = wdata;
                            clr_pulse[b*WORD_W +: WORD_W] =
                                wdata & ~st_q.clr[b*WORD_W +: WORD_W];
                        end
                    end
                    K_STAT: rdata = pending[b*WORD_W +: WORD_W];
                    default: rdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode = st_q.mode;
    assign both = st_q.both;
    assign pol  = st_q.pol;
    assign en   = st_q.en;
endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
    parameter int NPINS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] mode,
    input  logic [NPINS-1:0] both,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] en,
    input  logic [NPINS-1:0] clr_pulse,
    output logic [NPINS-1:0] pending,
    output logic             irq
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] lat;
        logic             irq;
    } det_t;

    det_t             st_q, st_d;
    logic [NPINS-1:0] rise, fall, hit;

    assign rise = pin_in & ~st_q.prev;
    assign fall = ~pin_in & st_q.prev;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign hit[i] = mode[i] &
            (both[i] ? (rise[i] | fall[i]) : (pol[i] ? rise[i] : fall[i]));
    end

    always_comb begin
        pending   = (mode & st_q.lat) | (~mode & (pin_in ^ pol));
        st_d.prev = pin_in;
        st_d.lat  = hit | (st_q.lat & ~clr_pulse & mode);
        st_d.irq  = |(pending & en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.irq;

    // R3
    level_nolatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(~mode)) & st_q.lat) == '0));
    // R4
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(st_q.lat & mode & ~clr_pulse)) & ~st_q.lat) == '0));
    // R6
    clear_applied_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(clr_pulse & ~hit)) & st_q.lat) == '0));
    // R7
    edge_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(hit)) & ~st_q.lat) == '0));
    // R8
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.irq |-> $past(|en));
endmodule

// File: rtl/pin_event_irq.sv
module pin_event_irq #(
    parameter int NPINS  = 64,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic              irq_out
);
    logic [NPINS-1:0] mode, both, pol, en, clr_pulse, pending;

    irq_cfg_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bus_we),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .pending   (pending),
        .mode      (mode),
        .both      (both),
        .pol       (pol),
        .en        (en),
        .clr_pulse (clr_pulse)
    );

    irq_pin_detect #(.NPINS(NPINS)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .mode      (mode),
        .both      (both),
        .pol       (pol),
        .en        (en),
        .clr_pulse (clr_pulse),
        .pending   (pending),
        .irq       (irq_out)
    );
endmodule

// File: tb/pin_event_irq_test.sv
`timescale 1ns/1ps
module pin_event_irq_test;
    localparam int KM = 0, KB = 1, KP = 2, KE = 3, KC = 4, KS = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] pin_in = '0;
    logic        irq_out;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [63:0] m_mode = '0, m_both = '0, m_pol = '0, m_en = '0, m_clr = '0;
    logic [63:0] m_prev = '0, m_lat = '0;
    logic        m_irq = 1'b0;

    always #2.5 clk = ~clk;

    pin_event_irq uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .irq_out(irq_out)
    );

    function automatic logic [63:0] pend_of(input logic [63:0] p);
        return (m_mode & m_lat) | (~m_mode & (p ^ m_pol));
    endfunction

    function automatic logic [31:0] model_rd(input int k, input int b,
                                             input logic [63:0] p);
        logic [63:0] v;
        case (k)
            KM: v = m_mode;
            KB: v = m_both;
            KP: v = m_pol;
            KE: v = m_en;
            KC: v = m_clr;
            KS: v = pend_of(p);
            default: v = '0;
        endcase
        return v[b*32 +: 32];
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cycle(input logic [63:0] p, input bit we, input int k,
                         input int b, input logic [31:0] wd,
                         input bit use_exp, input logic [31:0] exp,
                         input string tag);
        logic [63:0] rise, fall, hit, pulse, lat_n;
        logic        irq_n;
        pin_in    = p;
        bus_we    = we;
        bus_addr  = 6'(k*8 + b*4);
        bus_wdata = wd;
        #1;
        if (!we) begin
            check(bus_rdata == model_rd(k, b, p), tag,
                  64'(bus_rdata), 64'(model_rd(k, b, p)));
            if (use_exp) check(bus_rdata == exp, tag, 64'(bus_rdata), 64'(exp));
        end
        rise  = p & ~m_prev;
        fall  = ~p & m_prev;
        hit   = m_mode & ((m_both & (rise | fall)) | (~m_both & m_pol & rise) |
                          (~m_both & ~m_pol & fall));
        pulse = '0;
        if (we && k == KC) pulse[b*32 +: 32] = wd & ~m_clr[b*32 +: 32];
        lat_n = hit | (m_lat & ~pulse & m_mode);
        irq_n = |(pend_of(p) & m_en);
        @(posedge clk);
        m_lat  = lat_n;
        m_prev = p;
        m_irq  = irq_n;
        if (we) begin
            case (k)
                KM: m_mode[b*32 +: 32] = wd;
                KB: m_both[b*32 +: 32] = wd;
                KP: m_pol[b*32 +: 32]  = wd;
                KE: m_en[b*32 +: 32]   = wd;
                KC: m_clr[b*32 +: 32]  = wd;
                default: ;
            endcase
        end
        @(negedge clk);
        check(irq_out == m_irq, tag, 64'(irq_out), 64'(m_irq));
    endtask

    task automatic wr(input logic [63:0] p, input int k, input int b,
                      input logic [31:0] d, input string tag);
        cycle(p, 1'b1, k, b, d, 1'b0, '0, tag);
    endtask

    task automatic rd(input logic [63:0] p, input int k, input int b,
                      input logic [31:0] e, input string tag);
        cycle(p, 1'b0, k, b, '0, 1'b1, e, tag);
    endtask

    task automatic chk_irq(input logic e, input string tag);
        check(irq_out == e, tag, 64'(irq_out), 64'(e));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [63:0] p;
        int unused_seed;
        unused_seed = $urandom(32'd20240611);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk_irq(1'b0, "R2");
        rst_n = 1'b1;
        for (int k = 0; k < 6; k++)
            for (int b = 0; b < 2; b++) rd('0, k, b, 32'h0, "R2");

        // R1: bank layout and readback, R3 active-low level on pins 33 and 63
        wr('0, KP, 1, 32'h8000_0002, "R1");
        rd('0, KP, 1, 32'h8000_0002, "R1");
        rd('0, KP, 0, 32'h0, "R1");
        rd('0, KS, 1, 32'h8000_0002, "R3");
        wr('0, KE, 1, 32'h0000_0002, "R8");
        rd('0, KE, 1, 32'h0000_0002, "R1");
        chk_irq(1'b1, "R8");
        p = 64'h2 << 32;
        rd(p, KS, 1, 32'h8000_0000, "R3");
        chk_irq(1'b0, "R3");
        wr('0, KP, 1, 32'h0, "R3");
        wr('0, KE, 1, 32'h0, "R3");

        // R4: pin 5 rising, pin 6 falling
        wr('0, KM, 0, 32'h60, "R4");
        wr('0, KP, 0, 32'h20, "R4");
        wr('0, KE, 0, 32'h60, "R4");
        rd(64'h60, KS, 0, 32'h0, "R4");
        rd(64'h60, KS, 0, 32'h20, "R4");
        rd('0, KS, 0, 32'h20, "R4");
        rd('0, KS, 0, 32'h60, "R4");
        chk_irq(1'b1, "R8");
        rd('0, KS, 0, 32'h60, "R4");

        // R6: clear on 0-to-1 only
        wr('0, KC, 0, 32'h20, "R6");
        rd('0, KS, 0, 32'h40, "R6");
        rd('0, KC, 0, 32'h20, "R6");
        rd(64'h20, KS, 0, 32'h40, "R6");
        rd(64'h20, KS, 0, 32'h60, "R6");
        wr(64'h20, KC, 0, 32'h20, "R6");
        rd(64'h20, KS, 0, 32'h60, "R6");
        wr(64'h20, KC, 0, 32'h0, "R6");
        wr(64'h20, KC, 0, 32'h60, "R6");
        rd(64'h20, KS, 0, 32'h0, "R6");
        rd(64'h20, KS, 0, 32'h0, "R4");

        // R7: edge in the clear cycle survives
        wr(64'h20, KC, 0, 32'h0, "R7");
        rd('0, KS, 0, 32'h0, "R7");
        wr(64'h20, KC, 0, 32'h20, "R7");
        rd(64'h20, KS, 0, 32'h20, "R7");

        // R5: both edges on pin 7, polarity set but ignored
        wr(64'h20, KB, 0, 32'h80, "R5");
        wr(64'h20, KM, 0, 32'hE0, "R5");
        wr(64'h20, KP, 0, 32'hA0, "R5");
        rd(64'hA0, KS, 0, 32'h20, "R5");
        rd(64'hA0, KS, 0, 32'hA0, "R5");
        wr(64'hA0, KC, 0, 32'h80, "R5");
        rd(64'hA0, KS, 0, 32'h20, "R5");
        rd(64'h20, KS, 0, 32'h20, "R5");
        rd(64'h20, KS, 0, 32'hA0, "R5");

        // R8: masked sources stay in status but not on irq_out
        wr(64'h20, KE, 0, 32'h0, "R8");
        rd(64'h20, KS, 0, 32'hA0, "R8");
        chk_irq(1'b0, "R8");

        // Random phase against the bench model
        p = 64'h20;
        for (int n = 0; n < 4000; n++) begin
            int k, b;
            logic [31:0] d;
            p = p ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
            b = int'($urandom % 2);
            d = $urandom;
            if ($urandom % 5 == 0) begin
                k = int'($urandom % 5);
                wr(p, k, b, d, "R8");
            end else begin
                k = int'($urandom % 6);
                cycle(p, 1'b0, k, b, '0, 1'b0, '0, (k == KS) ? "R4" : "R1");
            end
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule